// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block keeps the address and remaining-transfer state for four DMA channels. Software-side logic loads a starting address, a transfer count and a mode byte for each channel through one write port. A separate strobe from the transfer sequencer names the channel that has just completed one transfer. On that strobe the channel's current address moves one step, up or down as its mode byte selects, and its current count drops by one.

A strobe that arrives while the current count is already zero marks the last transfer of the operation. The block then emits a one-cycle terminal pulse and sets a sticky per-channel terminal flag. If the channel's mode has auto-initialize set, the current address and count are restored from the base copies at that moment and the channel keeps running. If auto-initialize is clear, the count wraps to all ones and the channel refuses further strobes until it is loaded again. Bus timing, data movement and request arbitration belong to neighbouring blocks.

Top module: `dma_addr_engine`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) every current address, current count and mode byte reads zero, every terminal flag is clear and tc_pulse_o is low.
- R2: A write with wr_sel = 0 stores wr_data as the base address of channel wr_chan and loads the same value into that channel's current address at the same clock edge.
- R3: A write with wr_sel = 1 stores wr_data as the base count of channel wr_chan and loads the same value into that channel's current count at the same clock edge.
- R4: A write with wr_sel = 2 stores wr_data[7:0] as the mode byte of the channel given by wr_data[1:0]; wr_chan plays no part in a mode write.
- R5: A strobe on a running channel with mode bit 5 clear and a nonzero count adds one to its current address (wrapping at 16 bits) and subtracts one from its current count.
- R6: With mode bit 5 set, a strobe subtracts one from the channel's current address (wrapping at 16 bits) instead of adding one.
- R7: A strobe on a running channel whose current count is zero raises tc_pulse_o for exactly the following cycle and sets that channel's bit of tc_flag_o; with mode bit 4 clear the address still steps and the count becomes 0xFFFF.
- R8: With mode bit 4 set, that terminal strobe instead reloads the current address and current count from the base address and base count, and the channel keeps accepting strobes.
- R9: A channel whose terminal flag is set and whose mode bit 4 is clear ignores strobes; a base address or base count write to that channel clears its terminal flag and makes it run again.
- R10: A strobe alters only the channel named by xfer_chan; when a base address or base count write targets that same channel in the same cycle, the write takes effect and the strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 2 | Write target: 0 base address, 1 base count, 2 mode byte |
| wr_chan | input | 2 | Channel for base address and base count writes |
| wr_data | input | 16 | Write value |
| xfer_stb | input | 1 | One transfer completed on channel xfer_chan |
| xfer_chan | input | 2 | Channel the strobe belongs to |
| cur_addr_o | output | 64 | Current addresses, channel n at bits 16n+15:16n |
| cur_count_o | output | 64 | Current counts, channel n at bits 16n+15:16n |
| mode_o | output | 32 | Mode bytes, channel n at bits 8n+7:8n |
| tc_flag_o | output | 4 | Sticky terminal flag per channel |
| tc_pulse_o | output | 1 | One-cycle pulse after a terminal strobe |

## Verification
Every piece of channel state is visible on the ports one clock after it changes, so a wrong step direction, a missed decrement or a write landing on the wrong channel shows up on cur_addr_o or cur_count_o at the very next sample. Base registers are observed indirectly: a corrupted base address or base count appears only when an auto-initialize reload copies it out at the next terminal strobe, which can be many strobes later, so the stimulus uses small counts to reach reloads often. A halted channel that wrongly accepts a strobe moves its address on the following cycle, and a missing or doubled terminal event is seen on tc_pulse_o one cycle after the strobe.

// File: rtl/dma_ae_pkg.sv
// Package: shared constants and types for the DMA address/count engine.
// Assumes a single clock domain and that all users agree on mode bit
// positions and write-target encodings defined here.
package dma_ae_pkg;

    // Write target selector carried on wr_sel.
    typedef enum logic [1:0] {
        WR_BASE_ADDR  = 2'd0,
        WR_BASE_COUNT = 2'd1,
        WR_MODE       = 2'd2,
        WR_NONE       = 2'd3
    } wr_target_e;

    // Mode byte bit positions.
    localparam int MODE_DIR_BIT  = 5;  // 1: address counts down
    localparam int MODE_AUTO_BIT = 4;  // 1: reload from base at terminal count

endpackage

// File: rtl/dma_ae_wr_decode.sv
// Module: dma_ae_wr_decode
// Turns one register write into per-channel load strobes. Base writes are
// steered by the channel field; mode writes are steered by the low bits of
// the written value. Assumes at most one write per cycle.
module dma_ae_wr_decode
    import dma_ae_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [CH_W-1:0]   mode_chan,
    output logic [NUM_CH-1:0] ld_addr,
    output logic [NUM_CH-1:0] ld_count,
    output logic [NUM_CH-1:0] ld_mode
);

    wr_target_e target;

    // Interpret the selector as a write target.
    always_comb begin
        target = wr_target_e'(wr_sel);
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dec
        // Per-channel strobe generation for each write target.
        always_comb begin
            ld_addr[ch]  = wr_en && (target == WR_BASE_ADDR)  && (wr_chan == CH_W'(ch));
            ld_count[ch] = wr_en && (target == WR_BASE_COUNT) && (wr_chan == CH_W'(ch));
            ld_mode[ch]  = wr_en && (target == WR_MODE)       && (mode_chan == CH_W'(ch));
        end
    end

    AST_ONE_LOAD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_addr, ld_count, ld_mode})); // R4

endmodule

// File: rtl/dma_ae_channel.sv
// Module: dma_ae_channel
// State of one DMA channel: base and current address, base and current
// count, mode byte and sticky terminal flag. Assumes the strobe input is
// already qualified for this channel. A base write wins over a strobe in
// the same cycle; a mode write does not block a strobe, which then uses the
// previous mode byte.
module dma_ae_channel
    import dma_ae_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int MODE_W = 8,
    localparam int DATA_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr,
    input  logic              ld_count,
    input  logic              ld_mode,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              stb,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_count,
    output logic [MODE_W-1:0] mode,
    output logic              tc_flag,
    output logic              tc_hit
);

    localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);

    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  base_count;
    logic [ADDR_W-1:0] addr_stepped;
    logic              count_down;
    logic              auto_init;
    logic              halted;
    logic              base_wr;
    logic              step;
    logic              at_end;

    // Decode mode bits and the run/stop condition.
    always_comb begin
        count_down = mode[MODE_DIR_BIT];
        auto_init  = mode[MODE_AUTO_BIT];
        halted     = tc_flag && !auto_init;
        base_wr    = ld_addr || ld_count;
        step       = stb && !halted && !base_wr;
        at_end     = (cur_count == '0);
        tc_hit     = step && at_end;
    end

    // Next address one step in the programmed direction.
    always_comb begin
        addr_stepped = count_down ? (cur_addr - A_ONE) : (cur_addr + A_ONE);
    end

    // Base registers, loaded only by writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr  <= '0;
            base_count <= '0;
        end else begin
            if (ld_addr)  base_addr  <= wr_data[ADDR_W-1:0];
            if (ld_count) base_count <= wr_data[CNT_W-1:0];
        end
    end

    // Current address: write load, auto-init reload or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else if (ld_addr) begin
            cur_addr <= wr_data[ADDR_W-1:0];
        end else if (step) begin
            cur_addr <= (at_end && auto_init) ? base_addr : addr_stepped;
        end
    end

    // Current count: write load, terminal wrap/reload or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_count <= '0;
        end else if (ld_count) begin
            cur_count <= wr_data[CNT_W-1:0];
        end else if (step) begin
            if (at_end) cur_count <= auto_init ? base_count : '1;
            else        cur_count <= cur_count - C_ONE;
        end
    end

    // Mode byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= '0;
        else if (ld_mode) mode <= wr_data[MODE_W-1:0];
    end

    // Sticky terminal flag: set on terminal strobe, cleared by a base write.
    always_ff @(posedge clk) begin
        if (!rst_n)       tc_flag <= 1'b0;
        else if (base_wr) tc_flag <= 1'b0;
        else if (tc_hit)  tc_flag <= 1'b1;
    end

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_addr |=> (cur_addr == $past(wr_data[ADDR_W-1:0]))); // R2

    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_count |=> (cur_count == $past(wr_data[CNT_W-1:0]))); // R3

    AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !at_end) |=> (cur_count == $past(cur_count) - C_ONE)); // R5

    AST_ADDR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count_down && !(at_end && auto_init)) |=>
            (cur_addr == $past(cur_addr) - A_ONE)); // R6

    AST_TC_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        tc_hit |=> tc_flag); // R7

    AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_hit && auto_init) |=> (cur_count == base_count && cur_addr == base_addr)); // R8

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !base_wr) |=> ($stable(cur_addr) && $stable(cur_count))); // R9

endmodule

// File: rtl/dma_ae_tc_collect.sv
// Module: dma_ae_tc_collect
// Merges the per-channel terminal events into one registered pulse.
// Assumes at most one channel reports a terminal event per cycle, since
// only one channel can be strobed at a time.
module dma_ae_tc_collect #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] tc_hit,
    output logic              tc_pulse
);

    // Register the OR of all terminal events for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) tc_pulse <= 1'b0;
        else        tc_pulse <= |tc_hit;
    end

    AST_SINGLE_TC: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tc_hit)); // R10

    AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|tc_hit) |=> tc_pulse); // R7

    AST_PULSE_ONLY_AFTER_TC: assert property (@(posedge clk) disable iff (!rst_n)
        !(|tc_hit) |=> !tc_pulse); // R7

endmodule

// File: rtl/dma_addr_engine.sv
// Module: dma_addr_engine (top)
// Address and count engine for NUM_CH DMA channels. Decodes register
// writes, qualifies the transfer strobe for the named channel, keeps each
// channel's state in its own instance and flattens it onto the outputs.
// Assumes the strobe comes from a sequencer that serves one channel a cycle.
module dma_addr_engine
    import dma_ae_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int MODE_W = 8,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int DATA_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_sel,
    input  logic [CH_W-1:0]          wr_chan,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     xfer_stb,
    input  logic [CH_W-1:0]          xfer_chan,
    output logic [NUM_CH*ADDR_W-1:0] cur_addr_o,
    output logic [NUM_CH*CNT_W-1:0]  cur_count_o,
    output logic [NUM_CH*MODE_W-1:0] mode_o,
    output logic [NUM_CH-1:0]        tc_flag_o,
    output logic                     tc_pulse_o
);

    logic [NUM_CH-1:0] ld_addr;
    logic [NUM_CH-1:0] ld_count;
    logic [NUM_CH-1:0] ld_mode;
    logic [NUM_CH-1:0] ch_stb;
    logic [NUM_CH-1:0] tc_hit;

    dma_ae_wr_decode #(
        .NUM_CH (NUM_CH)
    ) i_wr_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_chan   (wr_chan),
        .mode_chan (wr_data[CH_W-1:0]),
        .ld_addr   (ld_addr),
        .ld_count  (ld_count),
        .ld_mode   (ld_mode)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // Route the transfer strobe only to the named channel.
        always_comb begin
            ch_stb[ch] = xfer_stb && (xfer_chan == CH_W'(ch));
        end

        dma_ae_channel #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .MODE_W (MODE_W)
        ) i_channel (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld_addr   (ld_addr[ch]),
            .ld_count  (ld_count[ch]),
            .ld_mode   (ld_mode[ch]),
            .wr_data   (wr_data),
            .stb       (ch_stb[ch]),
            .cur_addr  (cur_addr_o[ch*ADDR_W +: ADDR_W]),
            .cur_count (cur_count_o[ch*CNT_W +: CNT_W]),
            .mode      (mode_o[ch*MODE_W +: MODE_W]),
            .tc_flag   (tc_flag_o[ch]),
            .tc_hit    (tc_hit[ch])
        );
    end

    dma_ae_tc_collect #(
        .NUM_CH (NUM_CH)
    ) i_tc_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .tc_hit   (tc_hit),
        .tc_pulse (tc_pulse_o)
    );

    AST_STB_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_stb)); // R10

endmodule

// File: tb/test_dma_addr_engine.sv
// Bench for dma_addr_engine: directed corner cases followed by seeded
// random traffic, all compared each cycle against a bench-side model.
module test_dma_addr_engine;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [1:0]  wr_chan;
    logic [15:0] wr_data;
    logic        xfer_stb;
    logic [1:0]  xfer_chan;
    logic [63:0] cur_addr_o;
    logic [63:0] cur_count_o;
    logic [31:0] mode_o;
    logic [3:0]  tc_flag_o;
    logic        tc_pulse_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Bench model state.
    logic [15:0] m_base_a [NCH];
    logic [15:0] m_base_c [NCH];
    logic [15:0] m_cur_a  [NCH];
    logic [15:0] m_cur_c  [NCH];
    logic [7:0]  m_mode   [NCH];
    logic        m_flag   [NCH];
    logic        m_pulse;

    always #5 clk = ~clk;

    dma_addr_engine i_dma_addr_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_chan     (wr_chan),
        .wr_data     (wr_data),
        .xfer_stb    (xfer_stb),
        .xfer_chan   (xfer_chan),
        .cur_addr_o  (cur_addr_o),
        .cur_count_o (cur_count_o),
        .mode_o      (mode_o),
        .tc_flag_o   (tc_flag_o),
        .tc_pulse_o  (tc_pulse_o)
    );

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        for (int ch = 0; ch < NCH; ch++) begin
            check(tag, $sformatf("addr ch%0d", ch), cur_addr_o[ch*16 +: 16], m_cur_a[ch]);
            check(tag, $sformatf("count ch%0d", ch), cur_count_o[ch*16 +: 16], m_cur_c[ch]);
            check(tag, $sformatf("mode ch%0d", ch), {8'h00, mode_o[ch*8 +: 8]}, {8'h00, m_mode[ch]});
            check(tag, $sformatf("flag ch%0d", ch), {15'd0, tc_flag_o[ch]}, {15'd0, m_flag[ch]});
        end
        check(tag, "tc pulse", {15'd0, tc_pulse_o}, {15'd0, m_pulse});
    endtask

    task automatic model_reset();
        for (int ch = 0; ch < NCH; ch++) begin
            m_base_a[ch] = '0; m_base_c[ch] = '0; m_cur_a[ch] = '0;
            m_cur_c[ch]  = '0; m_mode[ch]   = '0; m_flag[ch]  = 1'b0;
        end
        m_pulse = 1'b0;
    endtask

    // Apply the requirement rules for one clock edge to the model.
    task automatic model_edge();
        logic [7:0] old_mode [NCH];
        m_pulse = 1'b0;
        for (int ch = 0; ch < NCH; ch++) old_mode[ch] = m_mode[ch];
        for (int ch = 0; ch < NCH; ch++) begin
            bit la, lc, lm, run, dn, au;
            la  = wr_en && wr_sel == 2'd0 && wr_chan == 2'(ch);
            lc  = wr_en && wr_sel == 2'd1 && wr_chan == 2'(ch);
            lm  = wr_en && wr_sel == 2'd2 && wr_data[1:0] == 2'(ch);
            dn  = old_mode[ch][5];
            au  = old_mode[ch][4];
            run = xfer_stb && xfer_chan == 2'(ch) && !(m_flag[ch] && !au) && !la && !lc;
            if (run) begin
                if (m_cur_c[ch] == 16'd0) begin
                    m_pulse    = 1'b1;
                    m_flag[ch] = 1'b1;
                    if (au) begin
                        m_cur_a[ch] = m_base_a[ch];
                        m_cur_c[ch] = m_base_c[ch];
                    end else begin
                        m_cur_a[ch] = dn ? m_cur_a[ch] - 16'd1 : m_cur_a[ch] + 16'd1;
                        m_cur_c[ch] = 16'hFFFF;
                    end
                end else begin
                    m_cur_a[ch] = dn ? m_cur_a[ch] - 16'd1 : m_cur_a[ch] + 16'd1;
                    m_cur_c[ch] = m_cur_c[ch] - 16'd1;
                end
            end
            if (la) begin m_base_a[ch] = wr_data; m_cur_a[ch] = wr_data; m_flag[ch] = 1'b0; end
            if (lc) begin m_base_c[ch] = wr_data; m_cur_c[ch] = wr_data; m_flag[ch] = 1'b0; end
            if (lm) m_mode[ch] = wr_data[7:0];
        end
    endtask

    // One cycle: drive at negedge, model the edge, compare at next negedge.
    task automatic cycle(string tag, bit we, logic [1:0] sel, logic [1:0] wch,
                         logic [15:0] dat, bit stb, logic [1:0] sch);
        wr_en = we; wr_sel = sel; wr_chan = wch; wr_data = dat;
        xfer_stb = stb; xfer_chan = sch;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic wr(string tag, logic [1:0] sel, logic [1:0] ch, logic [15:0] dat);
        cycle(tag, 1'b1, sel, ch, dat, 1'b0, 2'd0);
    endtask

    task automatic strobe(string tag, logic [1:0] ch);
        cycle(tag, 1'b0, 2'd0, 2'd0, 16'h0, 1'b1, ch);
    endtask

    initial begin
        bit dummy;
        dummy = 1'b0;
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_chan = 0; wr_data = 0;
        xfer_stb = 0; xfer_chan = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;

        // Base loads on channel 1.
        wr("R2", 2'd0, 2'd1, 16'h1000);
        wr("R3", 2'd1, 2'd1, 16'h0002);
        // Mode write steered by data bits, wr_chan ignored.
        wr("R4", 2'd2, 2'd3, 16'h0001);
        wr("R4", 2'd2, 2'd0, 16'h0022);
        // Count up and decrement.
        strobe("R5", 2'd1);
        strobe("R5", 2'd1);
        // Terminal strobe without auto-init: wrap to FFFF, flag, pulse.
        strobe("R7", 2'd1);
        cycle("R7", 1'b0, 2'd0, 2'd0, 16'h0, 1'b0, 2'd0);
        // Halted channel ignores strobes.
        strobe("R9", 2'd1);
        strobe("R9", 2'd1);
        // Reprogramming clears the flag and restarts the channel.
        wr("R9", 2'd1, 2'd1, 16'h0005);
        strobe("R9", 2'd1);
        // Count down on channel 2, including wrap below zero address.
        wr("R6", 2'd0, 2'd2, 16'h0001);
        wr("R6", 2'd1, 2'd2, 16'h0003);
        strobe("R6", 2'd2);
        strobe("R6", 2'd2);
        strobe("R6", 2'd2);
        // Auto-init on channel 3, zero base count: terminal every strobe.
        wr("R8", 2'd2, 2'd0, 16'h0013);
        wr("R8", 2'd0, 2'd3, 16'h2000);
        wr("R8", 2'd1, 2'd3, 16'h0000);
        strobe("R8", 2'd3);
        strobe("R8", 2'd3);
        wr("R8", 2'd1, 2'd3, 16'h0001);
        strobe("R8", 2'd3);
        strobe("R8", 2'd3);
        strobe("R8", 2'd3);
        // Address wrap at top going up on channel 0.
        wr("R5", 2'd0, 2'd0, 16'hFFFF);
        wr("R5", 2'd1, 2'd0, 16'h0004);
        strobe("R5", 2'd0);
        // Write and strobe same channel same cycle: write wins.
        cycle("R10", 1'b1, 2'd0, 2'd0, 16'h0ABC, 1'b1, 2'd0);
        cycle("R10", 1'b1, 2'd1, 2'd0, 16'h0007, 1'b1, 2'd0);
        // Write one channel while strobing another.
        cycle("R10", 1'b1, 2'd0, 2'd2, 16'h4444, 1'b1, 2'd0);

        // Seeded random traffic.
        for (int i = 0; i < 3000; i++) begin
            bit we, stb;
            logic [1:0] sel, wch, sch;
            logic [15:0] dat;
            we  = ($urandom % 10) < 3;
            sel = 2'($urandom % 3);
            wch = 2'($urandom);
            sch = 2'($urandom);
            stb = ($urandom % 10) < 7;
            case (sel)
                2'd1:    dat = 16'($urandom % 5);
                2'd2:    dat = 16'($urandom);
                default: dat = ($urandom % 2) ? 16'($urandom) : 16'hFFFE + 16'($urandom % 3);
            endcase
            cycle("R10", we, sel, wch, dat, stb, sch);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule